// File: doc/BRIEF.md
# Frequency Synthesiser Control Slave on I2C

This block is the serial control front end of a PLL frequency synthesiser. It listens on I2C as a slave. Its 7-bit address has five fixed upper bits and two lower bits taken from a pin-strapped select input. A master writes programming bytes into it and reads back one status byte. The programmed state drives the synthesiser datapath directly: a 17-bit loop division ratio, a prescaler enable, a reference divider select, a charge-pump current select and four general-purpose port outputs. The same state also selects what the shared reference/compare output carries.

A write transaction carries pairs of bytes after the address. The most significant bit of the first byte of each pair tells the pair's type. A 0 starts a divider pair and a 1 starts a control pair. The two kinds of pair may come in either order and both may appear in one transaction. A read returns a power-on flag, the loop lock flag and a 3-bit converter code. The power-on flag is set by reset or by a supply-fault event, and that event also restores every register to its default. The flag stays set until a read transaction is closed by a STOP. While it is set, the port outputs are not driven.

Setting the output-enable bit low and the select bit high puts the block in test mode. The three low port bits of the second control byte then become a test selector, and the stored port values stay as they were.

Top module: `synth_ctrl_i2c`

## Requirements
- R1: A byte after START is taken as the address when its upper seven bits equal 1100_0 followed by `addr_sel[1:0]`, and bit 0 is the direction (0 write, 1 read). A non-matching address gets no ACK, and the bytes that follow it change nothing until the next START.
- R2: After a matching address, the slave pulls SDA low during the ACK clock of the address and of every written byte. SDA changes only after an SCL falling edge or a START/STOP condition.
- R3: A written byte with bit 7 = 0 supplies division bits 14..8 from its bits 6..0. The next byte supplies division bits 7..0. Division bits 14..0 are updated only when that second byte is acknowledged.
- R4: A written byte with bit 7 = 1 holds division bit 16 in bit 6, bit 15 in bit 5, the prescaler enable in bit 4 and the reference select in bits 3..0. The next byte holds the charge-pump select in bits 7..6, RE in bit 5, RTS in bit 4, port 3 in bit 3 and ports 2..0 in bits 2..0. All of these commit together once the second byte is acknowledged.
- R5: Divider and control pairs may follow each other in either order within one transaction. A pair left unfinished at a START or STOP is dropped and has no effect.
- R6: A read returns the status byte {POR, lock, 0, 0, 0, adc[2:0]}, MSB first, and repeats it for as long as the master ACKs. The slave releases SDA during the master's ACK bit.
- R7: Reset or `por_evt` sets POR. It also restores the defaults: RE = RTS = 1, and every other field is 0. While POR is set, `port_oe` is 0000. POR is cleared only by a STOP that ends a read. After that, `port_oe` is 1111.
- R8: When the committed RE = 0 and RTS = 1, `test_mode` is 1 and bits 2..0 of the second control byte go to `test_sel`. `port_val[2:0]` keeps its earlier value and `port_val[3]` still updates.
- R9: `refcmp_o` is registered with one clock of latency. It carries `fref_i` when RE = 1 and RTS = 0, carries `fcomp_i` when RE = 1 and RTS = 1, and is 1 when RE = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (also sets POR) |
| por_evt | input | 1 | Supply fault pulse: sets POR and restores defaults |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel | input | 2 | Variable low address bits |
| lock_i | input | 1 | Loop lock indication |
| adc_code | input | 3 | Converter result for the status byte |
| fref_i | input | 1 | Reference frequency signal |
| fcomp_i | input | 1 | Comparison frequency signal |
| div_ratio | output | 17 | Programmable division ratio |
| pre_en | output | 1 | Prescaler enable |
| ref_sel | output | 4 | Reference divider select |
| cp_sel | output | 2 | Charge-pump current select |
| port_val | output | 4 | Port output values |
| port_oe | output | 4 | Port output enables |
| test_mode | output | 1 | Test mode active |
| test_sel | output | 3 | Test mode selector |
| refcmp_o | output | 1 | Reference/compare output |

## Verification
The assertions assume that SCL and SDA are slow against `clk`, and that each line stays stable for several clocks around every edge. Under that assumption the synchronised edge and START/STOP detection sees one clean event per bus edge. The stimulus meets this by holding every bus phase for six clocks and by changing SDA only while SCL is low, except for START and STOP. `por_evt` is pulsed only while the bus is idle, so no pair commit can coincide with it.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;
  parameter int DIV_W  = 17;
  parameter int REF_W  = 4;
  parameter int CP_W   = 2;
  parameter int PORT_W = 4;
  parameter int TS_W   = 3;
  parameter int ADC_W  = 3;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic              pe;
    logic [REF_W-1:0]  refd;
    logic [CP_W-1:0]   cp;
    logic              re;
    logic              rts;
    logic [PORT_W-1:0] port;
    logic [TS_W-1:0]   ts;
  } cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } bus_st_t;

  typedef enum logic [1:0] {PD_NONE, PD_DIV, PD_CTL} pend_t;

  localparam cfg_t CFG_DEFAULT = '{div: '0, pe: 1'b0, refd: '0, cp: '0,
                                   re: 1'b1, rts: 1'b1, port: '0, ts: '0};
endpackage

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import synth_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [6:0] dev_addr,
  input  logic [7:0] status,
  output logic       sda_low,
  output logic       wr_stb,
  output logic [7:0] wr_data,
  output logic       bus_cond,
  output logic       rd_stop
);
  localparam int CNT_W = 4;

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_s, sda_s;
  logic start_det, stop_det, scl_rise, scl_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1; sda_sh <= '1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;

  bus_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sh;
  logic             rw, rd_act, nack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; sda_low <= 1'b0; rw <= 1'b0;
      rd_act <= 1'b0; nack <= 1'b0; wr_stb <= 1'b0; wr_data <= '0;
      bus_cond <= 1'b0; rd_stop <= 1'b0;
    end else begin
      wr_stb   <= 1'b0;
      bus_cond <= 1'b0;
      rd_stop  <= 1'b0;
      if (start_det) begin
        st <= ST_ADDR; cnt <= '0; sda_low <= 1'b0; rd_act <= 1'b0; bus_cond <= 1'b1;
      end else if (stop_det) begin
        st <= ST_IDLE; sda_low <= 1'b0; rd_stop <= rd_act; rd_act <= 1'b0; bus_cond <= 1'b1;
      end else begin
        case (st)
          ST_ADDR, ST_WR: begin
            if (scl_rise && cnt < CNT_W'(8)) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end
            if (scl_fall && cnt == CNT_W'(8)) begin
              if (st == ST_WR) begin
                sda_low <= 1'b1; st <= ST_WACK;
              end else if (sh[7:1] == dev_addr) begin
                sda_low <= 1'b1; rw <= sh[0]; st <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              st <= ST_RD; sh <= status; sda_low <= ~status[7]; rd_act <= 1'b1;
            end else begin
              st <= ST_WR; sda_low <= 1'b0;
            end
          end
          ST_WACK: if (scl_fall) begin
            sda_low <= 1'b0; cnt <= '0; wr_stb <= 1'b1; wr_data <= sh; st <= ST_WR;
          end
          ST_RD: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            if (scl_fall) begin
              if (cnt == CNT_W'(8)) begin
                sda_low <= 1'b0; st <= ST_RACK;
              end else begin
                sh <= {sh[6:0], 1'b0}; sda_low <= ~sh[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) nack <= sda_s;
            if (scl_fall) begin
              if (nack) st <= ST_IDLE;
              else begin
                st <= ST_RD; cnt <= '0; sh <= status; sda_low <= ~status[7];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the data line only moves after a clock fall or a bus condition
  a_r2_sda_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_low) |-> $past(scl_fall || start_det || stop_det));

  // R6: the master's acknowledge bit is never overdriven
  a_r6_release_for_master: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RACK) |-> !sda_low);
endmodule

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs
  import synth_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       por_evt,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       bus_cond,
  input  logic       rd_stop,
  output cfg_t       cfg_q,
  output logic       por_q
);
  pend_t      pend;
  logic [6:0] hold;
  logic       tmode_byte;

  assign tmode_byte = ~wr_data[5] & wr_data[4];

  always_ff @(posedge clk) begin
    if (rst || por_evt) begin
      cfg_q <= CFG_DEFAULT; por_q <= 1'b1; pend <= PD_NONE; hold <= '0;
    end else begin
      if (rd_stop) por_q <= 1'b0;
      if (bus_cond) begin
        pend <= PD_NONE;
      end else if (wr_stb) begin
        case (pend)
          PD_NONE: begin
            hold <= wr_data[6:0];
            pend <= wr_data[7] ? PD_CTL : PD_DIV;
          end
          PD_DIV: begin
            cfg_q.div[14:0] <= {hold, wr_data};
            pend <= PD_NONE;
          end
          default: begin
            cfg_q.div[16:15] <= hold[6:5];
            cfg_q.pe         <= hold[4];
            cfg_q.refd       <= hold[3:0];
            cfg_q.cp         <= wr_data[7:6];
            cfg_q.re         <= wr_data[5];
            cfg_q.rts        <= wr_data[4];
            cfg_q.port[3]    <= wr_data[3];
            if (tmode_byte) cfg_q.ts <= wr_data[2:0];
            else            cfg_q.port[2:0] <= wr_data[2:0];
            pend <= PD_NONE;
          end
        endcase
      end
    end
  end

  // R3: low division bits move only on a write strobe or a supply fault
  a_r3_div_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q.div[7:0]) |-> $past(wr_stb || por_evt));

  // R7: the power-on flag drops only after a stop that closed a read
  a_r7_por_clear_by_read: assert property (@(posedge clk) disable iff (rst)
    $fell(por_q) |-> $past(rd_stop));

  // R8: a test-mode control byte leaves the low port bits unchanged
  a_r8_ports_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !bus_cond && !por_evt && pend == PD_CTL && tmode_byte)
      |=> $stable(cfg_q.port[2:0]));
endmodule

// File: rtl/synth_out_map.sv
module synth_out_map
  import synth_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  cfg_t              cfg,
  input  logic              por_flag,
  input  logic              fref_i,
  input  logic              fcomp_i,
  output logic [DIV_W-1:0]  div_ratio,
  output logic              pre_en,
  output logic [REF_W-1:0]  ref_sel,
  output logic [CP_W-1:0]   cp_sel,
  output logic [PORT_W-1:0] port_val,
  output logic [PORT_W-1:0] port_oe,
  output logic              test_mode,
  output logic [TS_W-1:0]   test_sel,
  output logic              refcmp_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      div_ratio <= '0; pre_en <= 1'b0; ref_sel <= '0; cp_sel <= '0;
      port_val <= '0; test_mode <= 1'b0; test_sel <= '0; refcmp_o <= 1'b1;
    end else begin
      div_ratio <= cfg.div;
      pre_en    <= cfg.pe;
      ref_sel   <= cfg.refd;
      cp_sel    <= cfg.cp;
      port_val  <= cfg.port;
      test_mode <= ~cfg.re & cfg.rts;
      test_sel  <= cfg.ts;
      refcmp_o  <= cfg.re ? (cfg.rts ? fcomp_i : fref_i) : 1'b1;
    end
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_oe
    always_ff @(posedge clk) begin
      if (rst) port_oe[i] <= 1'b0;
      else     port_oe[i] <= ~por_flag;
    end
  end

  // R7: ports float while the power-on flag is up
  a_r7_ports_float: assert property (@(posedge clk) disable iff (rst)
    $past(por_flag) |-> (port_oe == '0));

  // R9: a disabled reference output rests high
  a_r9_disabled_high: assert property (@(posedge clk) disable iff (rst)
    $past(!cfg.re) |-> refcmp_o);
endmodule

// File: rtl/synth_ctrl_i2c.sv
module synth_ctrl_i2c
  import synth_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_HI     = 5'b11000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_evt,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_sel,
  input  logic              lock_i,
  input  logic [ADC_W-1:0]  adc_code,
  input  logic              fref_i,
  input  logic              fcomp_i,
  output logic [DIV_W-1:0]  div_ratio,
  output logic              pre_en,
  output logic [REF_W-1:0]  ref_sel,
  output logic [CP_W-1:0]   cp_sel,
  output logic [PORT_W-1:0] port_val,
  output logic [PORT_W-1:0] port_oe,
  output logic              test_mode,
  output logic [TS_W-1:0]   test_sel,
  output logic              refcmp_o
);
  localparam int PAD_W = 8 - 2 - ADC_W;

  logic       wr_stb, bus_cond, rd_stop, por_q;
  logic [7:0] wr_data, status;
  cfg_t       cfg_q;

  assign status = {por_q, lock_i, {PAD_W{1'b0}}, adc_code};

  i2c_slave_engine #(.SYNC_STAGES(SYNC_STAGES)) u_eng (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .dev_addr({ADDR_HI, addr_sel}), .status(status), .sda_low(sda_oe),
    .wr_stb(wr_stb), .wr_data(wr_data), .bus_cond(bus_cond), .rd_stop(rd_stop)
  );

  synth_cfg_regs u_regs (
    .clk(clk), .rst(rst), .por_evt(por_evt), .wr_stb(wr_stb), .wr_data(wr_data),
    .bus_cond(bus_cond), .rd_stop(rd_stop), .cfg_q(cfg_q), .por_q(por_q)
  );

  synth_out_map u_map (
    .clk(clk), .rst(rst), .cfg(cfg_q), .por_flag(por_q), .fref_i(fref_i),
    .fcomp_i(fcomp_i), .div_ratio(div_ratio), .pre_en(pre_en), .ref_sel(ref_sel),
    .cp_sel(cp_sel), .port_val(port_val), .port_oe(port_oe), .test_mode(test_mode),
    .test_sel(test_sel), .refcmp_o(refcmp_o)
  );
endmodule

// File: tb/synth_ctrl_i2c_test.sv
`timescale 1ns/1ps
module synth_ctrl_i2c_test;
  localparam int H = 6;

  logic clk = 0, rst = 1, por_evt = 0;
  logic m_scl = 1, m_sda = 1;
  logic [1:0] addr_sel = 2'b10;
  logic lock = 0, fref = 0, fcomp = 0;
  logic [2:0] adc = 0;
  logic sda_oe, sda_line;
  logic [16:0] div_ratio; logic pre_en; logic [3:0] ref_sel; logic [1:0] cp_sel;
  logic [3:0] port_val, port_oe; logic test_mode; logic [2:0] test_sel; logic refcmp_o;

  assign sda_line = m_sda & ~sda_oe;
  always #2.5 clk = ~clk;

  synth_ctrl_i2c uut (
    .clk(clk), .rst(rst), .por_evt(por_evt), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .addr_sel(addr_sel), .lock_i(lock), .adc_code(adc),
    .fref_i(fref), .fcomp_i(fcomp), .div_ratio(div_ratio), .pre_en(pre_en),
    .ref_sel(ref_sel), .cp_sel(cp_sel), .port_val(port_val), .port_oe(port_oe),
    .test_mode(test_mode), .test_sel(test_sel), .refcmp_o(refcmp_o)
  );

  int checks = 0, failures = 0;
  logic busy = 1, cmp_en = 0;

  // behavioural reference state
  logic [16:0] m_div; logic m_pe; logic [3:0] m_ref; logic [1:0] m_cp;
  logic m_re, m_rts, m_por; logic [3:0] m_p; logic [2:0] m_ts;
  int m_pend; logic [6:0] m_hold;
  logic fref_d = 0, fcomp_d = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_defaults();
    m_div = 0; m_pe = 0; m_ref = 0; m_cp = 0; m_re = 1; m_rts = 1;
    m_p = 0; m_ts = 0; m_por = 1; m_pend = 0; m_hold = 0;
  endtask

  task automatic model_byte(input logic [7:0] d);
    if (m_pend == 0) begin
      m_hold = d[6:0]; m_pend = d[7] ? 2 : 1;
    end else begin
      if (m_pend == 1) m_div[14:0] = {m_hold, d};
      else begin
        m_div[16:15] = m_hold[6:5]; m_pe = m_hold[4]; m_ref = m_hold[3:0];
        m_cp = d[7:6]; m_re = d[5]; m_rts = d[4]; m_p[3] = d[3];
        if (!d[5] && d[4]) m_ts = d[2:0]; else m_p[2:0] = d[2:0];
      end
      m_pend = 0;
    end
  endtask

  always @(negedge clk) begin
    if (fref_cnt_tick(3)) fref = ~fref;
    if (fref_cnt_tick(5)) fcomp = ~fcomp;
  end
  int tick = 0;
  always @(posedge clk) begin tick <= tick + 1; fref_d <= fref; fcomp_d <= fcomp; end
  function automatic bit fref_cnt_tick(input int n); return (tick % n) == 0; endfunction

  // every-clock comparison against the reference while the bus is quiet
  always @(negedge clk) begin
    if (cmp_en && !busy) begin
      check(div_ratio == m_div, "R3 div_ratio", div_ratio, m_div);
      check(pre_en == m_pe && ref_sel == m_ref, "R4 pe/ref", {pre_en, ref_sel}, {m_pe, m_ref});
      check(cp_sel == m_cp, "R4 cp_sel", cp_sel, m_cp);
      check(port_val == m_p, "R8 port_val", port_val, m_p);
      check(test_mode == (!m_re && m_rts) && test_sel == m_ts, "R8 test",
            {test_mode, test_sel}, {!m_re && m_rts, m_ts});
      check(port_oe == (m_por ? 4'h0 : 4'hF), "R7 port_oe", port_oe, m_por ? 4'h0 : 4'hF);
      check(refcmp_o == (m_re ? (m_rts ? fcomp_d : fref_d) : 1'b1), "R9 refcmp",
            refcmp_o, m_re ? (m_rts ? fcomp_d : fref_d) : 1'b1);
    end
  end

  task automatic hold(input int n); repeat (n) @(negedge clk); endtask
  task automatic b_start(); m_sda = 1; m_scl = 1; hold(H); m_sda = 0; hold(H); m_scl = 0; hold(H); endtask
  task automatic b_stop(); m_sda = 0; hold(H); m_scl = 1; hold(H); m_sda = 1; hold(H); endtask
  task automatic b_out(input logic b); m_sda = b; hold(H); m_scl = 1; hold(H); m_scl = 0; hold(H); endtask
  task automatic b_in(output logic b);
    m_sda = 1; hold(H); m_scl = 1; hold(H/2); b = sda_line; hold(H - H/2); m_scl = 0; hold(H);
  endtask
  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) b_out(d[i]);
    b_in(a); acked = !a;
  endtask

  task automatic wr_tx(input logic [7:0] ab, input int n, input logic [7:0] d0, d1, d2, d3,
                       input bit do_stop, input string tag);
    logic [7:0] dv [4]; logic ak; bit match;
    dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
    match = (ab[7:1] == {5'b11000, addr_sel});
    busy = 1; m_pend = 0;
    b_start();
    send_byte(ab, ak);
    check(ak == match, {tag, " R1 addr ack"}, ak, match);
    for (int i = 0; i < n; i++) begin
      send_byte(dv[i], ak);
      check(ak == match, {tag, " R2 data ack"}, ak, match);
      if (match) model_byte(dv[i]);
    end
    if (do_stop) b_stop();
    m_pend = 0;
    hold(10); busy = 0;
  endtask

  task automatic rd_tx(input int n, input string tag);
    logic [7:0] d, e; logic b;
    busy = 1;
    b_start();
    send_byte({5'b11000, addr_sel, 1'b1}, b);
    check(b == 1, {tag, " R1 read addr ack"}, b, 1);
    for (int k = 0; k < n; k++) begin
      e = {m_por, lock, 3'b000, adc};
      for (int i = 7; i >= 0; i--) begin b_in(b); d[i] = b; end
      check(d == e, {tag, " R6 status"}, d, e);
      b_out(k == n - 1);
    end
    b_stop();
    m_por = 0;
    hold(10); busy = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_defaults();
    hold(4); rst = 0; hold(4);
    cmp_en = 1; busy = 0;
    hold(20);
    // R7 reset state: ports float, compare frequency routed out
    check(port_oe == 4'h0 && div_ratio == 0, "R7 reset state", {port_oe, div_ratio}, 0);

    // R6/R7: first read shows POR and clears it
    lock = 1; adc = 3'd5;
    rd_tx(1, "t1");
    hold(5);
    check(port_oe == 4'hF, "R7 POR cleared by read+stop", port_oe, 4'hF);

    // R3/R4: divider then control in one write
    wr_tx(8'hC4, 4, 8'h12, 8'h34, 8'hE5, 8'hB5, 1, "t2");
    check(div_ratio == 17'h19234, "R3 R4 div literal", div_ratio, 17'h19234);

    // R1: non-matching address ignored
    wr_tx(8'hC0, 4, 8'h00, 8'h00, 8'h80, 8'h00, 1, "t3");
    check(div_ratio == 17'h19234 && port_val == 4'b0101, "R1 ignored", {port_val, div_ratio}, {4'b0101, 17'h19234});

    // R5/R9: control first, then divider; RE=1 RTS=0 routes fref
    wr_tx(8'hC4, 4, 8'h9A, 8'h6B, 8'h05, 8'hFF, 1, "t4");
    check(pre_en == 1 && ref_sel == 4'hA, "R4 pe/ref", {pre_en, ref_sel}, 5'h1A);

    // R8: test mode keeps ports 2..0
    wr_tx(8'hC4, 2, 8'h80, 8'h5E, 0, 0, 1, "t5");
    check(port_val == 4'b1011 && test_sel == 3'd6 && test_mode == 1, "R8 test select",
          {test_mode, port_val, test_sel}, {1'b1, 4'b1011, 3'd6});
    check(refcmp_o == 1'b1, "R9 disabled high", refcmp_o, 1);

    // R5: half pair dropped at stop, fresh pair starts afterwards
    wr_tx(8'hC4, 1, 8'h07, 0, 0, 0, 1, "t6");
    check(div_ratio[14:0] == 15'h05FF, "R5 half pair dropped", div_ratio, 15'h05FF);
    wr_tx(8'hC4, 2, 8'h22, 8'h44, 0, 0, 1, "t7");
    check(div_ratio[14:0] == {7'h22, 8'h44}, "R5 new pair", div_ratio[14:0], {7'h22, 8'h44});

    // R9: back to compare frequency, other address strap
    addr_sel = 2'b01;
    wr_tx(8'hC2, 2, 8'h80, 8'h30, 0, 0, 1, "t8");

    // R7: supply fault restores defaults; a write does not clear POR
    busy = 1; @(negedge clk); por_evt = 1; @(negedge clk); por_evt = 0;
    model_defaults(); hold(6); busy = 0; hold(4);
    check(port_oe == 4'h0 && div_ratio == 0, "R7 fault defaults", {port_oe, div_ratio}, 0);
    wr_tx(8'hC2, 2, 8'h01, 8'h02, 0, 0, 1, "t9");
    check(port_oe == 4'h0, "R7 write keeps POR", port_oe, 0);

    // R6: multi-byte read, unlocked, repeats status
    lock = 0; adc = 3'd2;
    rd_tx(2, "t10");
    hold(5);
    check(port_oe == 4'hF, "R7 cleared again", port_oe, 4'hF);
    rd_tx(1, "t11");
    hold(20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule